// File: doc/BRIEF.md
# Address/Command SPI Slave Register Interface

This block is the serial front end of a peripheral that holds a small byte-wide register space. A host talks to it over a four-wire SPI link in clock mode 1: the clock idles low, the host changes MOSI after each rising SCK edge, and both sides sample on the falling edge. Every frame opens with an 8-bit word. Its top bit says whether the word is a direct command or a register address. A command is passed to the rest of the chip as a one-cycle strobe that carries a 5-bit code. An address word opens a register access. The access is either a read or a write, and either touches a single register or runs through consecutive registers in auto-increment mode.

The top of the register space, 0x1F, is a data window onto a FIFO. A continuous access that reaches it stays there, so any number of bytes can be streamed through the window in one frame. Reads are fetched one byte ahead, so that the first bit of each read byte is ready before the host's next rising edge. The register contents, the FIFO and anything that acts on commands live outside this block, behind a simple read/write port.

All SPI pins are brought into the system clock domain through a synchronizer. Each SCK phase, high and low, must therefore last at least 8 system clock cycles.

Top module: `adrcmd_spi_slave`

## Requirements
- R1: After reset, reg_wr_en, reg_rd_en, cmd_valid and spi_miso are all 0.
- R2: A first word with bit 7 = 1 is a command. It raises cmd_valid for exactly one clock, with cmd_code equal to word bits 4..0, and starts no register access.
- R3: After a command word, the next byte in the same frame is decoded again as a first word, so several commands and then an address word can share one frame.
- R4: A first word with bit 7 = 0 is an address word: bit 6 = 1 means read, bit 6 = 0 means write, bit 5 = 1 means continuous, and bits 4..0 give the start address. In single write mode (bit 5 = 0), exactly one reg_wr_en pulse is issued, for the byte after the word, and any further bytes in the frame are ignored.
- R5: In continuous write mode, each data byte produces one reg_wr_en pulse, and the address rises by one per byte, starting at the given address.
- R6: A read word issues a reg_rd_en pulse for its address. reg_rd_data is sampled in that cycle, and the byte is shifted out on spi_miso during the next byte. MOSI content during read bytes causes no write.
- R7: In continuous read mode, the read for address A+1 is issued at the end of each byte that returns address A, so the frame returns consecutive registers. In single read mode, only one read is issued, and later bytes return 0.
- R8: In continuous mode, once the address reaches the FIFO window 0x1F it stays at 0x1F for all further bytes of the frame, for both reads and writes.
- R9: Raising spi_cs_n discards any partial byte without a register access or command. The next frame starts with a fresh first word.
- R10: Bytes travel MSB first. spi_mosi is sampled on the falling SCK edge, and spi_miso changes only after a rising SCK edge or when chip select goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, mode 1, idles low |
| spi_cs_n | input | 1 | Active-low chip select; bounds a frame |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 5 | Register address for the current access |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Write data, valid with reg_wr_en |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_data | input | 8 | Read data, sampled in the reg_rd_en cycle |
| cmd_valid | output | 1 | One-cycle direct command strobe |
| cmd_code | output | 5 | Command code, valid with cmd_valid |

## Verification
A wrong decoder state shows up at the register port within one byte time. A misread type or direction bit gives a strobe of the wrong kind, and a stale address or a missing hold at 0x1F gives the wrong reg_addr on the next strobe. The scoreboard therefore compares every strobe in order, and treats any strobe it did not expect as a fault. A bad shift counter or a bad load of the transmit register corrupts the byte the host reads back in the very next byte, so every returned byte is compared as well. A frame cut short must be followed by a command that decodes correctly, which exposes any state left behind.

// File: rtl/adrcmd_pkg.sv
package adrcmd_pkg;
   // Frame decoder phases: expecting a first word, writing, reading, ignoring.
   typedef enum logic [1:0] {
      FR_WORD  = 2'd0,
      FR_WRITE = 2'd1,
      FR_READ  = 2'd2,
      FR_DRAIN = 2'd3
   } frame_st_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_pin,
   input  logic cs_n_pin,
   input  logic mosi_pin,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_act,
   output logic mosi_s
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sclk_c, cs_c, mosi_c;
   logic              sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_c <= '0;
         cs_c   <= '1;
         mosi_c <= '0;
         sclk_d <= 1'b0;
      end else begin
         sclk_c <= {sclk_c[STAGES-2:0], sclk_pin};
         cs_c   <= {cs_c[STAGES-2:0], cs_n_pin};
         mosi_c <= {mosi_c[STAGES-2:0], mosi_pin};
         sclk_d <= sclk_c[STAGES-1];
      end
   end

   assign cs_act    = ~cs_c[STAGES-1];
   assign mosi_s    = mosi_c[STAGES-1];
   assign sclk_rise = cs_act &  sclk_c[STAGES-1] & ~sclk_d;
   assign sclk_fall = cs_act & ~sclk_c[STAGES-1] &  sclk_d;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi_s,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_data,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              miso
);
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_byte_shifter: DATA_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sr, tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sr     <= '0;
         tx_sr     <= '0;
         miso      <= 1'b0;
         byte_done <= 1'b0;
      end else if (!cs_act) begin
         bit_cnt   <= '0;
         rx_sr     <= '0;
         tx_sr     <= '0;
         miso      <= 1'b0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sclk_fall) begin
            rx_sr <= {rx_sr[DATA_W-2:0], mosi_s};
            if (bit_cnt == LAST_BIT) begin
               bit_cnt   <= '0;
               byte_done <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
         if (load_en) begin
            tx_sr <= load_data;
         end else if (sclk_rise) begin
            miso  <= tx_sr[DATA_W-1];
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
         end
      end
   end

   assign rx_byte = rx_sr;

   // R10: the output bit only moves after a rising edge or on deselect
   assert_miso_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso) |-> ($past(sclk_rise) || !$past(cs_act)));

   // R9: a deselected link holds no partial byte
   assert_idle_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (bit_cnt == '0 && !byte_done));
endmodule

// File: rtl/spi_frame_decoder.sv
module spi_frame_decoder
   import adrcmd_pkg::*;
#(
   parameter int              DATA_W    = 8,
   parameter int              ADDR_W    = 5,
   parameter logic [ADDR_W-1:0] FIFO_ADDR = '1,
   parameter bit              HOLD_FIFO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              reg_rd_en,
   output logic              cmd_valid,
   output logic [ADDR_W-1:0] cmd_code
);
   localparam int TYPE_BIT = DATA_W - 1;
   localparam int RW_BIT   = DATA_W - 2;
   localparam int CONT_BIT = DATA_W - 3;

   generate
      if (DATA_W < ADDR_W + 3) begin : g_bad_word
         $error("spi_frame_decoder: DATA_W must be at least ADDR_W + 3");
      end
   endgenerate

   frame_st_t         state;
   logic [ADDR_W-1:0] addr_q, addr_nxt;
   logic              cont_q;

   // Address advance: either hold at the FIFO window or wrap freely.
   generate
      if (HOLD_FIFO) begin : g_hold
         assign addr_nxt = (addr_q == FIFO_ADDR) ? addr_q : addr_q + 1'b1;
      end else begin : g_wrap
         assign addr_nxt = addr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= FR_WORD;
         addr_q      <= '0;
         cont_q      <= 1'b0;
         reg_addr    <= '0;
         reg_wr_en   <= 1'b0;
         reg_wr_data <= '0;
         reg_rd_en   <= 1'b0;
         cmd_valid   <= 1'b0;
         cmd_code    <= '0;
      end else begin
         reg_wr_en <= 1'b0;
         reg_rd_en <= 1'b0;
         cmd_valid <= 1'b0;
         if (!cs_act) begin
            state <= FR_WORD;
         end else if (byte_done) begin
            unique case (state)
               FR_WORD: begin
                  if (rx_byte[TYPE_BIT]) begin
                     cmd_valid <= 1'b1;
                     cmd_code  <= rx_byte[ADDR_W-1:0];
                  end else begin
                     addr_q <= rx_byte[ADDR_W-1:0];
                     cont_q <= rx_byte[CONT_BIT];
                     if (rx_byte[RW_BIT]) begin
                        reg_rd_en <= 1'b1;
                        reg_addr  <= rx_byte[ADDR_W-1:0];
                        state     <= FR_READ;
                     end else begin
                        state <= FR_WRITE;
                     end
                  end
               end
               FR_WRITE: begin
                  reg_wr_en   <= 1'b1;
                  reg_addr    <= addr_q;
                  reg_wr_data <= rx_byte;
                  if (cont_q) addr_q <= addr_nxt;
                  else        state  <= FR_DRAIN;
               end
               FR_READ: begin
                  if (cont_q) begin
                     addr_q    <= addr_nxt;
                     reg_addr  <= addr_nxt;
                     reg_rd_en <= 1'b1;
                  end else begin
                     state <= FR_DRAIN;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R4: at most one kind of strobe per cycle
   assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_wr_en, reg_rd_en, cmd_valid}));

   // R2: a command strobe lasts one cycle
   assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R4/R7: a single-mode frame issues nothing once draining
   assert_drain_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_DRAIN && $past(state == FR_DRAIN)) |-> (!reg_wr_en && !reg_rd_en));

   generate
      if (HOLD_FIFO) begin : g_hold_chk
         // R8: within a data phase the FIFO window address never moves
         assert_fifo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cs_act && state != FR_WORD && addr_q == FIFO_ADDR) |=> addr_q == FIFO_ADDR);
      end
   endgenerate
endmodule

// File: rtl/adrcmd_spi_slave.sv
module adrcmd_spi_slave #(
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 5,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] FIFO_ADDR   = '1,
   parameter bit                HOLD_FIFO   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              reg_rd_en,
   input  logic [DATA_W-1:0] reg_rd_data,
   output logic              cmd_valid,
   output logic [ADDR_W-1:0] cmd_code
);
   logic              sclk_rise, sclk_fall, cs_act, mosi_s, byte_done;
   logic [DATA_W-1:0] rx_byte;

   spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_pin (spi_sclk),
      .cs_n_pin (spi_cs_n),
      .mosi_pin (spi_mosi),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .cs_act   (cs_act),
      .mosi_s   (mosi_s)
   );

   spi_byte_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .mosi_s   (mosi_s),
      .load_en  (reg_rd_en),
      .load_data(reg_rd_data),
      .byte_done(byte_done),
      .rx_byte  (rx_byte),
      .miso     (spi_miso)
   );

   spi_frame_decoder #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .FIFO_ADDR(FIFO_ADDR),
      .HOLD_FIFO(HOLD_FIFO)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .reg_addr   (reg_addr),
      .reg_wr_en  (reg_wr_en),
      .reg_wr_data(reg_wr_data),
      .reg_rd_en  (reg_rd_en),
      .cmd_valid  (cmd_valid),
      .cmd_code   (cmd_code)
   );

   // R1: all strobes are low while reset is applied
   always_comb begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (!reg_wr_en && !reg_rd_en && !cmd_valid && !spi_miso);
      end
   end
endmodule

// File: tb/adrcmd_spi_slave_bench.sv
module adrcmd_spi_slave_bench;
   localparam int HALF = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic       spi_miso;
   logic [4:0] reg_addr, cmd_code;
   logic       reg_wr_en, reg_rd_en, cmd_valid;
   logic [7:0] reg_wr_data, reg_rd_data;

   always #2 clk = ~clk;

   adrcmd_spi_slave u_adrcmd_spi_slave (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
      .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
      .reg_rd_data(reg_rd_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code)
   );

   // Bench-side register file
   logic [7:0] mem [32];
   initial for (int i = 0; i < 32; i++) mem[i] = 8'(i * 7 + 1);
   always @(posedge clk) if (reg_wr_en) mem[reg_addr] <= reg_wr_data;
   assign reg_rd_data = mem[reg_addr];

   int n_chk = 0, n_bad = 0;
   logic [15:0] exp_q[$];
   logic [7:0]  tx_buf [16];
   logic [7:0]  rx_buf [16];

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Item encoding: {kind[1:0], 1'b0, addr[4:0], data[7:0]}; kind 1 write, 2 read, 3 command
   function automatic logic [15:0] item(input logic [1:0] k, input logic [4:0] a, input logic [7:0] d);
      return {k, 1'b0, a, d};
   endfunction

   task automatic pop_cmp(input string req, input logic [15:0] act);
      if (exp_q.size() == 0) chk({req, " unexpected"}, act, 16'h0);
      else chk(req, act, exp_q.pop_front());
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr_en) pop_cmp("R4/R5/R8 write", item(2'd1, reg_addr, reg_wr_data));
         if (reg_rd_en) pop_cmp("R6/R7/R8 read", item(2'd2, reg_addr, 8'h00));
         if (cmd_valid) pop_cmp("R2/R3 cmd", item(2'd3, cmd_code, 8'h00));
      end
   end

   task automatic xfer_bits(input logic [7:0] b, input int nbits, output logic [7:0] r);
      r = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         @(negedge clk); spi_sclk = 1'b1; spi_mosi = b[i];
         repeat (HALF) @(negedge clk);
         r[i] = spi_miso; spi_sclk = 1'b0;
         repeat (HALF) @(negedge clk);
      end
   endtask

   task automatic frame(input int n, input int tail_bits);
      logic [7:0] r;
      @(negedge clk); spi_cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int k = 0; k < n; k++) begin
         xfer_bits(tx_buf[k], 8, r);
         rx_buf[k] = r;
      end
      if (tail_bits > 0) xfer_bits(tx_buf[n], tail_bits, r);
      repeat (4) @(negedge clk); spi_cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 reset strobes", {12'h0, reg_wr_en, reg_rd_en, cmd_valid, spi_miso}, 16'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 idle after reset", {12'h0, reg_wr_en, reg_rd_en, cmd_valid, spi_miso}, 16'h0);

      // R4 single write, trailing byte ignored
      exp_q.push_back(item(2'd1, 5'h05, 8'hA5));
      tx_buf[0] = 8'h05; tx_buf[1] = 8'hA5; tx_buf[2] = 8'h3C; frame(3, 0);
      // R6 single read, MOSI ignored; R7 later bytes return 0
      exp_q.push_back(item(2'd2, 5'h05, 8'h00));
      tx_buf[0] = 8'h45; tx_buf[1] = 8'hFF; tx_buf[2] = 8'hFF; frame(3, 0);
      chk("R6 single read data", {8'h0, rx_buf[1]}, 16'h00A5);
      chk("R7 single read trailing byte", {8'h0, rx_buf[2]}, 16'h0000);
      chk("R6 first word returns 0", {8'h0, rx_buf[0]}, 16'h0000);

      // R5 continuous write, R10 bit order with asymmetric value
      exp_q.push_back(item(2'd1, 5'h03, 8'hC1));
      exp_q.push_back(item(2'd1, 5'h04, 8'h22));
      exp_q.push_back(item(2'd1, 5'h05, 8'h33));
      tx_buf[0] = 8'h23; tx_buf[1] = 8'hC1; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33; frame(4, 0);
      // R7 continuous read with prefetch
      for (int a = 3; a <= 6; a++) exp_q.push_back(item(2'd2, 5'(a), 8'h00));
      tx_buf[0] = 8'h63; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00; frame(4, 0);
      chk("R10 MSB-first readback", {8'h0, rx_buf[1]}, 16'h00C1);
      chk("R7 continuous read 2nd", {8'h0, rx_buf[2]}, 16'h0022);
      chk("R7 continuous read 3rd", {8'h0, rx_buf[3]}, 16'h0033);

      // R2 lone command
      exp_q.push_back(item(2'd3, 5'h0F, 8'h00));
      tx_buf[0] = 8'h8F; frame(1, 0);
      // R3 commands then continuous write; R8 FIFO hold on writes
      exp_q.push_back(item(2'd3, 5'h0F, 8'h00));
      exp_q.push_back(item(2'd3, 5'h11, 8'h00));
      exp_q.push_back(item(2'd1, 5'h1D, 8'h00));
      exp_q.push_back(item(2'd1, 5'h1E, 8'h30));
      exp_q.push_back(item(2'd1, 5'h1F, 8'h26));
      exp_q.push_back(item(2'd1, 5'h1F, 8'h01));
      exp_q.push_back(item(2'd1, 5'h1F, 8'h5A));
      tx_buf[0] = 8'h8F; tx_buf[1] = 8'h91; tx_buf[2] = 8'h3D; tx_buf[3] = 8'h00;
      tx_buf[4] = 8'h30; tx_buf[5] = 8'h26; tx_buf[6] = 8'h01; tx_buf[7] = 8'h5A;
      frame(8, 0);
      // R8 FIFO hold on continuous reads
      exp_q.push_back(item(2'd2, 5'h1E, 8'h00));
      for (int k = 0; k < 3; k++) exp_q.push_back(item(2'd2, 5'h1F, 8'h00));
      tx_buf[0] = 8'h7E; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00; frame(4, 0);
      chk("R8 read before window", {8'h0, rx_buf[1]}, 16'h0030);
      chk("R8 window read 1", {8'h0, rx_buf[2]}, 16'h005A);
      chk("R8 window read 2", {8'h0, rx_buf[3]}, 16'h005A);

      // R9 partial first word: nothing issued, then fresh command decodes
      tx_buf[0] = 8'h85; frame(0, 5);
      exp_q.push_back(item(2'd3, 5'h01, 8'h00));
      tx_buf[0] = 8'h81; frame(1, 0);
      // R9 partial data byte: no write; readback shows old value
      tx_buf[0] = 8'h07; tx_buf[1] = 8'hEE; frame(1, 3);
      exp_q.push_back(item(2'd2, 5'h07, 8'h00));
      tx_buf[0] = 8'h47; tx_buf[1] = 8'h00; frame(2, 0);
      chk("R9 aborted write left register", {8'h0, rx_buf[1]}, {8'h0, 8'(7 * 7 + 1)});

      chk("R2/R9 all expected strobes seen", 16'(exp_q.size()), 16'h0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule